// File: doc/BRIEF.md
# External Interrupt Sense and Latch Block

This block watches sixteen maskable interrupt input lines and one non-maskable input. Every line passes through a two-stage synchroniser. A per-line sense mode then decides whether a low level, a falling edge, a rising edge or either edge counts as an event. Each event is held in a per-line pending flag, and the flag stays set until software clears it. A flag reaches the request output only when the line's enable bit is set.

For lines 2 to 15, a per-line source bit chooses which pin the line watches: the primary pin or an alternate pin. The non-maskable input has a configurable active edge and its own pending flag. That flag drives the non-maskable request directly, with no mask or mode in the path.

Software reaches the configuration through a simple write strobe, an address and a data word. Read data is combinational from the same address. Pin direction has no effect on detection, because the block only ever samples the pins.

Top module: `irq_sense_top`

## Requirements
- R1: Register map: address 0 holds the sense modes of lines 7..0, address 1 the modes of lines 15..8, address 2 the enables, address 3 the source selects, address 4 the pending flags, and address 5 the non-maskable control (bit 0 = edge select, bit 1 = pending). After reset every address reads 0 and both request outputs are 0.
- R2: Line n's mode is the 2-bit field at bits [2(n mod 8)+1 : 2(n mod 8)] of address 0 or 1. Mode 00 sets the flag in every cycle in which the synchronised input is low. Any detected input change reaches the flag on the third rising clock edge after the pin changes.
- R3: Mode 01 sets the flag on a high-to-low transition only.
- R4: Mode 10 sets the flag on a low-to-high transition only.
- R5: Mode 11 sets the flag on either transition.
- R6: Request bit n equals flag n AND enable bit n, where the enables are bits 15..0 of address 2.
- R7: A flag is set by an event even while its enable is 0. Writing the enable to 1 afterwards raises the request on the next cycle.
- R8: Writing address 4 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1. A flag stays set until such a clear.
- R9: If an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: For lines 2..15, bit n of address 3 set to 1 selects the alternate pin and 0 selects the primary pin. Lines 0 and 1 always use the primary pin, and bits 1..0 of address 3 read 0.
- R11: The non-maskable pending flag (address 5 bit 1) is set by a falling edge when bit 0 is 0 and by a rising edge when bit 0 is 1. Writing address 5 with bit 1 = 0 clears it.
- R12: The non-maskable request output equals its pending flag, independent of all enables, modes and source selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPin | input | 16 | Primary interrupt pins, one per line |
| irqAlt | input | 14 | Alternate pins for lines 15..2 |
| nmiPin | input | 1 | Non-maskable interrupt pin |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr |
| irqReq | output | 16 | Per-line gated interrupt requests |
| nmiReq | output | 1 | Non-maskable interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in exactly the same cycle as a fresh edge event. The bench lowers a pin at a falling clock edge, counts two rising edges for the synchroniser, and then holds the clear write across the third rising edge, so the flag register sees both at once.

Level mode gives a second route to the same collision. There the pin is held low while the clear is written, and the flag must survive.

A sweep over every line and every mode drives falling and rising edges in turn. It compares flags and gated requests against values computed from the mode number and an alternating enable pattern.

// File: rtl/irq_sense_pkg.sv
`timescale 1ns/1ps
package irq_sense_pkg;
  localparam int IRQ_LINES = 16;
  localparam int ALT_FIRST = 2;
  localparam int ADDR_W    = 3;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef struct packed {
    logic [IRQ_LINES-1:0] flagClr;
    logic                 nmiClr;
  } clr_strobe_t;

  localparam logic [ADDR_W-1:0] ADDR_MODE_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SOURCE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_NMI     = 3'd5;
endpackage

// File: rtl/irq_sense_ctrl.sv
`timescale 1ns/1ps
module irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int LINES = IRQ_LINES,
  parameter int ALT   = ALT_FIRST
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [LINES-1:0]     regWdata,
  output logic [LINES-1:0]     regRdata,
  input  logic [LINES-1:0]     flagQ,
  input  logic                 nmiPend,
  output logic [2*LINES-1:0]   modeCfg,
  output logic [LINES-1:0]     enableCfg,
  output logic [LINES-1:ALT]   srcCfg,
  output logic                 nmiRise,
  output clr_strobe_t          strobes
);
  localparam int DATA_W = LINES;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCfg   <= '0;
      enableCfg <= '0;
      srcCfg    <= '0;
      nmiRise   <= 1'b0;
    end else if (regWrite) begin
      case (regAddr)
        ADDR_MODE_LO: modeCfg[DATA_W-1:0]        <= regWdata;
        ADDR_MODE_HI: modeCfg[2*DATA_W-1:DATA_W] <= regWdata;
        ADDR_ENABLE:  enableCfg                  <= regWdata;
        ADDR_SOURCE:  srcCfg                     <= regWdata[LINES-1:ALT];
        ADDR_NMI:     nmiRise                    <= regWdata[0];
        default: ;
      endcase
    end
  end

  // clear strobes toward the datapath (write 0 to clear)
  always_comb begin
    strobes.flagClr = '0;
    strobes.nmiClr  = 1'b0;
    if (regWrite && regAddr == ADDR_FLAGS) strobes.flagClr = ~regWdata;
    if (regWrite && regAddr == ADDR_NMI)   strobes.nmiClr  = ~regWdata[1];
  end

  // read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_MODE_LO: regRdata = modeCfg[DATA_W-1:0];
      ADDR_MODE_HI: regRdata = modeCfg[2*DATA_W-1:DATA_W];
      ADDR_ENABLE:  regRdata = enableCfg;
      ADDR_SOURCE:  regRdata = {srcCfg, {ALT{1'b0}}};
      ADDR_FLAGS:   regRdata = flagQ;
      ADDR_NMI:     regRdata = {{(DATA_W-2){1'b0}}, nmiPend, nmiRise};
      default:      regRdata = '0;
    endcase
  end

  // R10: a source write lands in the select register on the next cycle
  assert_src_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_SOURCE) |=> (srcCfg == $past(regWdata[LINES-1:ALT])));

  // R6: an enable write lands on the next cycle
  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_ENABLE) |=> (enableCfg == $past(regWdata)));
endmodule

// File: rtl/irq_sense_path.sv
`timescale 1ns/1ps
module irq_sense_path
  import irq_sense_pkg::*;
#(
  parameter int LINES       = IRQ_LINES,
  parameter int ALT         = ALT_FIRST,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LINES-1:0]     irqPin,
  input  logic [LINES-1:ALT]   irqAlt,
  input  logic                 nmiPin,
  input  logic [2*LINES-1:0]   modeCfg,
  input  logic [LINES-1:0]     enableCfg,
  input  logic [LINES-1:ALT]   srcCfg,
  input  logic                 nmiRise,
  input  clr_strobe_t          strobes,
  output logic [LINES-1:0]     flagQ,
  output logic [LINES-1:0]     irqReq,
  output logic                 nmiPend
);
  logic [LINES-1:0] evtVec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic                   pinSel;
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   curLvl;
    sense_e                 mode;

    if (i >= ALT) begin : g_alt
      assign pinSel = srcCfg[i] ? irqAlt[i] : irqPin[i];
    end else begin : g_pri
      assign pinSel = irqPin[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        prevQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], pinSel};
        prevQ <= syncQ[SYNC_STAGES-1];
      end
    end

    assign curLvl = syncQ[SYNC_STAGES-1];
    assign mode   = sense_e'(modeCfg[2*i +: 2]);

    always_comb begin
      case (mode)
        SENSE_LOW:  evtVec[i] = ~curLvl;
        SENSE_FALL: evtVec[i] = prevQ & ~curLvl;
        SENSE_RISE: evtVec[i] = ~prevQ & curLvl;
        default:    evtVec[i] = prevQ ^ curLvl;
      endcase
    end

    // R8: a flag with no clear strobe keeps its value
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[i] && !strobes.flagClr[i]) |=> flagQ[i]);
    // R9: an event always leaves the flag set, even under a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |=> flagQ[i]);
    // R2: a flag only rises after a detection event
    assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[i]) |-> $past(evtVec[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~strobes.flagClr) | evtVec;
  end

  assign irqReq = flagQ & enableCfg;

  // non-maskable input
  logic [SYNC_STAGES-1:0] nmiSyncQ;
  logic                   nmiPrevQ;
  logic                   nmiEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiSyncQ <= '1;
      nmiPrevQ <= 1'b1;
      nmiPend  <= 1'b0;
    end else begin
      nmiSyncQ <= {nmiSyncQ[SYNC_STAGES-2:0], nmiPin};
      nmiPrevQ <= nmiSyncQ[SYNC_STAGES-1];
      nmiPend  <= (nmiPend & ~strobes.nmiClr) | nmiEvt;
    end
  end

  assign nmiEvt = nmiRise ? (~nmiPrevQ & nmiSyncQ[SYNC_STAGES-1])
                          : (nmiPrevQ & ~nmiSyncQ[SYNC_STAGES-1]);

  // R12: a non-maskable event is never blocked
  assert_nmi_pass_R12: assert property (@(posedge clk) disable iff (!rstN)
    nmiEvt |=> nmiPend);
endmodule

// File: rtl/irq_sense_top.sv
`timescale 1ns/1ps
module irq_sense_top
  import irq_sense_pkg::*;
#(
  parameter int LINES       = IRQ_LINES,
  parameter int ALT         = ALT_FIRST,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LINES-1:0]     irqPin,
  input  logic [LINES-1:ALT]   irqAlt,
  input  logic                 nmiPin,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [LINES-1:0]     regWdata,
  output logic [LINES-1:0]     regRdata,
  output logic [LINES-1:0]     irqReq,
  output logic                 nmiReq
);
  logic [2*LINES-1:0] modeCfg;
  logic [LINES-1:0]   enableCfg;
  logic [LINES-1:ALT] srcCfg;
  logic               nmiRise;
  logic [LINES-1:0]   flagQ;
  logic               nmiPend;
  clr_strobe_t        strobes;

  irq_sense_ctrl #(.LINES(LINES), .ALT(ALT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .flagQ(flagQ), .nmiPend(nmiPend),
    .modeCfg(modeCfg), .enableCfg(enableCfg), .srcCfg(srcCfg), .nmiRise(nmiRise),
    .strobes(strobes)
  );

  irq_sense_path #(.LINES(LINES), .ALT(ALT), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN),
    .irqPin(irqPin), .irqAlt(irqAlt), .nmiPin(nmiPin),
    .modeCfg(modeCfg), .enableCfg(enableCfg), .srcCfg(srcCfg), .nmiRise(nmiRise),
    .strobes(strobes),
    .flagQ(flagQ), .irqReq(irqReq), .nmiPend(nmiPend)
  );

  assign nmiReq = nmiPend;
endmodule

// File: tb/test_irq_sense_top.sv
`timescale 1ns/1ps
module test_irq_sense_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqPin = 16'hFFFF;
  logic [15:2] irqAlt = 14'h3FFF;
  logic        nmiPin = 1'b1;
  logic        regWrite = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic [15:0] irqReq;
  logic        nmiReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_sense_top i_irq_sense_top (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .irqAlt(irqAlt), .nmiPin(nmiPin),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqReq(irqReq), .nmiReq(nmiReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string modeTag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rdReg(3'(a), rd);
      chk("R1 reset register", rd, 0);
    end
    chk("R1 reset irqReq", irqReq, 0);
    chk("R1 reset nmiReq", nmiReq, 0);

    // sweep every line and mode: R2 R3 R4 R5 R6 R8
    for (int ln = 0; ln < 16; ln++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] bitv, mw;
        logic en, expF, expR;
        bitv = 16'h1 << ln;
        mw   = 16'(m) << (2 * (ln % 8));
        en   = 1'((ln + m) % 2);
        expF = (m != 2);
        expR = (m >= 2) || (m == 0);
        wrReg(3'd0, ln < 8 ? mw : 16'h0);
        wrReg(3'd1, ln < 8 ? 16'h0 : mw);
        wrReg(3'd2, en ? bitv : 16'h0);
        wrReg(3'd4, 16'h0);
        irqPin[ln] = 1'b0;
        settle();
        rdReg(3'd4, rd);
        chk({modeTag(m), " flag after fall"}, rd, expF ? bitv : 16'h0);
        chk("R6 gated request after fall", irqReq, (expF && en) ? bitv : 16'h0);
        wrReg(3'd4, ~bitv);
        rdReg(3'd4, rd);
        chk((m == 0) ? "R9 level held through clear" : "R8 clear", rd, (m == 0) ? bitv : 16'h0);
        irqPin[ln] = 1'b1;
        settle();
        rdReg(3'd4, rd);
        chk({modeTag(m), " flag after rise"}, rd, expR ? bitv : 16'h0);
        wrReg(3'd4, ~bitv);
        rdReg(3'd4, rd);
        chk("R8 flag cleared", rd, 16'h0);
      end
    end

    // all lines falling-edge from here on
    wrReg(3'd0, 16'h5555);
    wrReg(3'd1, 16'h5555);
    wrReg(3'd2, 16'h0);
    wrReg(3'd4, 16'h0);

    // R8: a write of 1 keeps the flag
    irqPin[3] = 1'b0;
    settle();
    wrReg(3'd4, 16'hFFFF);
    rdReg(3'd4, rd);
    chk("R8 write one keeps flag", rd, 16'h0008);
    irqPin[3] = 1'b1;
    settle();
    wrReg(3'd4, 16'h0);

    // R7: pending before enable
    irqPin[9] = 1'b0;
    settle();
    chk("R7 request held off while disabled", irqReq, 16'h0);
    rdReg(3'd4, rd);
    chk("R7 flag set while disabled", rd, 16'h0200);
    wrReg(3'd2, 16'h0200);
    chk("R7 request after enable", irqReq, 16'h0200);
    irqPin[9] = 1'b1;
    settle();
    wrReg(3'd4, 16'h0);
    wrReg(3'd2, 16'h0);

    // R9: edge event and clear in the same cycle
    irqPin[5] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrite = 1'b1; regAddr = 3'd4; regWdata = ~16'h0020;
    @(negedge clk);
    regWrite = 1'b0;
    rdReg(3'd4, rd);
    chk("R9 coincident set survives clear", rd, 16'h0020);
    wrReg(3'd4, 16'h0);
    rdReg(3'd4, rd);
    chk("R9 later clear removes flag", rd, 16'h0);
    irqPin[5] = 1'b1;
    settle();

    // R10: alternate source for lines 2..15
    for (int ln = 2; ln < 16; ln++) begin
      logic [15:0] bitv;
      bitv = 16'h1 << ln;
      wrReg(3'd3, bitv);
      irqAlt[ln] = 1'b0;
      settle();
      rdReg(3'd4, rd);
      chk("R10 alternate pin detected", rd, bitv);
      wrReg(3'd4, 16'h0);
      irqPin[ln] = 1'b0;
      settle();
      rdReg(3'd4, rd);
      chk("R10 primary pin ignored when alternate chosen", rd, 16'h0);
      irqPin[ln] = 1'b1;
      irqAlt[ln] = 1'b1;
      settle();
      wrReg(3'd4, 16'h0);
    end
    wrReg(3'd3, 16'hFFFF);
    rdReg(3'd3, rd);
    chk("R10 low select bits read zero", rd, 16'hFFFC);
    irqPin[0] = 1'b0;
    settle();
    rdReg(3'd4, rd);
    chk("R10 line 0 stays on primary", rd, 16'h0001);
    irqPin[0] = 1'b1;
    settle();
    wrReg(3'd3, 16'h0);
    wrReg(3'd4, 16'h0);

    // R11 R12: non-maskable input, all enables off
    nmiPin = 1'b0;
    settle();
    rdReg(3'd5, rd);
    chk("R11 falling edge pending", rd, 16'h0002);
    chk("R12 request with all masks off", nmiReq, 1'b1);
    wrReg(3'd5, 16'h0);
    rdReg(3'd5, rd);
    chk("R11 pending cleared", rd, 16'h0);
    nmiPin = 1'b1;
    settle();
    rdReg(3'd5, rd);
    chk("R11 rising ignored in falling mode", rd, 16'h0);
    wrReg(3'd5, 16'h0003);
    rdReg(3'd5, rd);
    chk("R11 edge select written", rd, 16'h0001);
    nmiPin = 1'b0;
    settle();
    rdReg(3'd5, rd);
    chk("R11 falling ignored in rising mode", rd, 16'h0001);
    nmiPin = 1'b1;
    settle();
    rdReg(3'd5, rd);
    chk("R11 rising edge pending", rd, 16'h0003);
    wrReg(3'd0, 16'h0);
    wrReg(3'd2, 16'h0);
    chk("R12 request unaffected by mode and enable", nmiReq, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule